// File: doc/BRIEF.md
# Periodic Refresh Request Scheduler

This block decides when a memory controller must run its refresh. It does not build refresh commands itself. Three control registers hold the refresh interval, the start address of a refresh command sequence already stored in the sequence memory, and an enable flag. When the programmed interval has passed, the block raises a request. The controller's arbiter answers with a grant. The sequence player then runs the stored sequence at the presented address. That sequence issues the refresh, waits out the refresh recovery time and finally reports completion on a done input.

Time is counted in units of a fixed prescale of clock cycles, 32 by default. The interval counter only runs while no granted sequence is in flight, and it starts again from zero when done arrives. The arbiter may leave a request waiting. Intervals that pass while a request is waiting are recorded in a small saturating debt counter, and each one is replayed by asserting the request again directly after a completion. Small interval values such as 8 are fully supported, so that short simulation runs still see refreshes.

Top module: `refresh_sched`

## Requirements
- R1: After a synchronous reset, `ref_req` is 0, `ref_addr` is 0, the interval register is 0 and enable is 0.
- R2: A write with `cfg_sel` = 1 loads `cfg_wdata[ADDR_W-1:0]` into the start address, and the new value shows on `ref_addr` from the next cycle on. A write with `cfg_sel` = 3 changes nothing. Writes with `cfg_sel` = 0 load the interval from `cfg_wdata[7:0]`, and writes with `cfg_sel` = 2 load enable from `cfg_wdata[0]`.
- R3: With enable 1 and interval N > 0, `ref_req` rises exactly N*32 clock edges after the edge that sampled the configuration write completing the setup.
- R4: While enable is 0 or the interval is 0, no request is raised. Clearing enable while a request is waiting withdraws it at the second edge after the write and discards any debt.
- R5: A raised request stays high until `ref_grant` is sampled high, and it is low in the cycle after that grant.
- R6: From grant until `seq_done` no request is raised and the interval does not advance. The next request rises N*32 edges after the edge that sampled `seq_done`, when no debt is owed.
- R7: An interval that passes while a request is waiting adds one to the debt. A completion with debt owed raises the request again in the next cycle and lowers the debt by one.
- R8: The debt saturates at 7, so at most 7 replayed requests follow the one that was waiting.
- R9: `seq_done` has no effect unless a granted sequence is in flight.
- R10: Writing the interval register restarts the interval count from zero, even when the same value is written again.
- R11: An interval value of 8 gives a request after 256 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Control register write strobe |
| cfg_sel | input | 2 | Register select: 0 interval, 1 start address, 2 enable, 3 none |
| cfg_wdata | input | CFG_W | Control register write data |
| ref_grant | input | 1 | Arbiter grant for the pending refresh |
| seq_done | input | 1 | Completion pulse from the sequence player |
| ref_req | output | 1 | Refresh request |
| ref_addr | output | ADDR_W | Start address of the stored refresh sequence |

## Verification
The assertions assume that the arbiter grants only while a request is high and that `seq_done` marks the end of a granted sequence. They also assume that configuration writes are single-cycle strobes. The bench raises `ref_grant` only after it has seen `ref_req` high, and it pulses `seq_done` for one cycle right after a grant. The only exception is the deliberate stray completion pulses, which it drives in the idle and waiting states. Grants are issued well inside one interval, except in the debt tests, where requests are left waiting on purpose for a counted number of intervals.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PEND = 2'd1,
    ST_BUSY = 2'd2
  } rfsh_state_e;

  localparam logic [1:0] SEL_IVAL = 2'd0;
  localparam logic [1:0] SEL_ADDR = 2'd1;
  localparam logic [1:0] SEL_EN   = 2'd2;
endpackage

// File: rtl/rfsh_cfg_regs.sv
module rfsh_cfg_regs
  import rfsh_pkg::*;
#(
  parameter int CFG_W  = 12,
  parameter int IVAL_W = 8,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [IVAL_W-1:0] ival_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic              en_q,
  output logic              ival_wr
);
  // bits left over for the narrower registers are intentionally not stored
  logic unused_wdata;
  assign unused_wdata = ^cfg_wdata;

  assign ival_wr = cfg_we && (cfg_sel == SEL_IVAL);

  always_ff @(posedge clk) begin
    if (rst) begin
      ival_q <= '0;
      addr_q <= '0;
      en_q   <= 1'b0;
    end else if (cfg_we) begin
      case (cfg_sel)
        SEL_IVAL: ival_q <= cfg_wdata[IVAL_W-1:0];
        SEL_ADDR: addr_q <= cfg_wdata[ADDR_W-1:0];
        SEL_EN:   en_q   <= cfg_wdata[0];
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/rfsh_tick_timer.sv
module rfsh_tick_timer #(
  parameter int IVAL_W   = 8,
  parameter int PRESCALE = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              restart,
  input  logic [IVAL_W-1:0] ival,
  output logic              elapse
);
  localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  logic              pre_wrap;
  logic              hold;
  logic [IVAL_W-1:0] int_q;
  logic              last_unit;

  assign hold = rst || !run || restart;

  generate
    if (PRESCALE > 1) begin : g_pre
      logic [PRE_W-1:0] pre_q;
      assign pre_wrap = (pre_q == PRE_W'(PRESCALE - 1));
      always_ff @(posedge clk) begin
        if (hold)          pre_q <= '0;
        else if (pre_wrap) pre_q <= '0;
        else               pre_q <= pre_q + PRE_W'(1);
      end
    end else begin : g_nopre
      assign pre_wrap = 1'b1;
    end
  endgenerate

  assign last_unit = (int_q == ival - IVAL_W'(1));
  assign elapse    = !hold && pre_wrap && last_unit;

  always_ff @(posedge clk) begin
    if (hold)           int_q <= '0;
    else if (pre_wrap)  int_q <= last_unit ? '0 : int_q + IVAL_W'(1);
  end
endmodule

// File: rtl/rfsh_req_fsm.sv
module rfsh_req_fsm
  import rfsh_pkg::*;
#(
  parameter int DEBT_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active,
  input  logic              elapse,
  input  logic              grant,
  input  logic              done,
  output logic              req,
  output logic              busy,
  output logic [DEBT_W-1:0] debt
);
  localparam logic [DEBT_W-1:0] DEBT_MAX = {DEBT_W{1'b1}};

  rfsh_state_e       state_q;
  logic [DEBT_W-1:0] debt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      debt_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (elapse) state_q <= ST_PEND;
        ST_PEND: begin
          if (!active) begin
            state_q <= ST_IDLE;
            debt_q  <= '0;
          end else begin
            if (grant) state_q <= ST_BUSY;
            if (elapse && debt_q != DEBT_MAX) debt_q <= debt_q + DEBT_W'(1);
          end
        end
        ST_BUSY: begin
          if (done) begin
            if (active && debt_q != '0) begin
              state_q <= ST_PEND;
              debt_q  <= debt_q - DEBT_W'(1);
            end else begin
              state_q <= ST_IDLE;
              if (!active) debt_q <= '0;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req  = (state_q == ST_PEND);
  assign busy = (state_q == ST_BUSY);
  assign debt = debt_q;
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
  import rfsh_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int IVAL_W   = 8,
  parameter int PRESCALE = 32,
  parameter int DEBT_W   = 3,
  parameter int CFG_W    = (ADDR_W > IVAL_W) ? ADDR_W : IVAL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              ref_grant,
  input  logic              seq_done,
  output logic              ref_req,
  output logic [ADDR_W-1:0] ref_addr
);
  logic [IVAL_W-1:0] ival_q;
  logic              en_q;
  logic              ival_wr;
  logic              active;
  logic              busy;
  logic              elapse;
  logic [DEBT_W-1:0] debt;

  rfsh_cfg_regs #(.CFG_W(CFG_W), .IVAL_W(IVAL_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .ival_q(ival_q), .addr_q(ref_addr),
    .en_q(en_q), .ival_wr(ival_wr)
  );

  assign active = en_q && (ival_q != '0);

  rfsh_tick_timer #(.IVAL_W(IVAL_W), .PRESCALE(PRESCALE)) u_timer (
    .clk(clk), .rst(rst), .run(active && !busy), .restart(ival_wr),
    .ival(ival_q), .elapse(elapse)
  );

  rfsh_req_fsm #(.DEBT_W(DEBT_W)) u_fsm (
    .clk(clk), .rst(rst), .active(active), .elapse(elapse),
    .grant(ref_grant), .done(seq_done), .req(ref_req), .busy(busy),
    .debt(debt)
  );
endmodule

// File: rtl/refresh_sched_chk.sv
module refresh_sched_chk
  import rfsh_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DEBT_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_we,
  input logic [1:0]        cfg_sel,
  input logic [ADDR_W-1:0] cfg_addr,
  input logic              ref_grant,
  input logic              seq_done,
  input logic              ref_req,
  input logic [ADDR_W-1:0] ref_addr,
  input logic              active,
  input logic              busy,
  input logic [DEBT_W-1:0] debt
);
  localparam logic [DEBT_W-1:0] DEBT_MAX = {DEBT_W{1'b1}};

  // R1
  rst_clear_chk: assert property (@(posedge clk)
    rst |=> (!ref_req && ref_addr == '0));

  // R2
  addr_load_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_sel == SEL_ADDR) |=> (ref_addr == $past(cfg_addr)));

  // R4
  off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !active |=> !ref_req);

  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ref_req && !ref_grant && active) |=> ref_req);

  // R5
  grant_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (ref_req && ref_grant) |=> !ref_req);

  // R6
  busy_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !seq_done) |=> (busy && !ref_req));

  // R7
  debt_replay_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && seq_done && active && debt != '0) |=> ref_req);

  // R8
  debt_cap_chk: assert property (@(posedge clk) disable iff (rst)
    (ref_req && !ref_grant && active && debt == DEBT_MAX) |=> (debt == DEBT_MAX));
endmodule

bind refresh_sched refresh_sched_chk #(.ADDR_W(ADDR_W), .DEBT_W(DEBT_W)) u_chk (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
  .cfg_addr(cfg_wdata[ADDR_W-1:0]), .ref_grant(ref_grant),
  .seq_done(seq_done), .ref_req(ref_req), .ref_addr(ref_addr),
  .active(active), .busy(busy), .debt(debt)
);

// File: tb/sim_refresh_sched.sv
`timescale 1ns/1ps
module sim_refresh_sched;
  localparam int ADDR_W = 12;
  localparam int CFG_W  = 12;
  localparam int NVEC   = 5;
  // interval value, expected cycles until request
  localparam int TBL [NVEC][2] = '{'{1, 32}, '{2, 64}, '{3, 96}, '{5, 160}, '{8, 256}};

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cfg_we = 1'b0;
  logic [1:0]        cfg_sel = 2'd3;
  logic [CFG_W-1:0]  cfg_wdata = '0;
  logic              ref_grant = 1'b0;
  logic              seq_done = 1'b0;
  logic              ref_req;
  logic [ADDR_W-1:0] ref_addr;

  int nchk = 0;
  int nfail = 0;

  always #2.5 clk = ~clk;

  refresh_sched u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .ref_grant(ref_grant), .seq_done(seq_done),
    .ref_req(ref_req), .ref_addr(ref_addr)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] sel, input int data);
    cfg_we = 1'b1;
    cfg_sel = sel;
    cfg_wdata = CFG_W'(data);
    tick();
    cfg_we = 1'b0;
    cfg_sel = 2'd3;
  endtask

  task automatic wait_req(output int k);
    k = 0;
    while (!ref_req && k < 4000) begin
      tick();
      k++;
    end
  endtask

  task automatic serve();
    ref_grant = 1'b1;
    tick();
    ref_grant = 1'b0;
    seq_done = 1'b1;
    tick();
    seq_done = 1'b0;
  endtask

  task automatic quiet(input int n, output bit seen);
    seen = 1'b0;
    for (int j = 0; j < n; j++) begin
      tick();
      if (ref_req) seen = 1'b1;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    int  k;
    int  n;
    bit  seen;
    tick(); tick(); tick();
    rst = 1'b0;
    tick();
    // R1 reset state
    check(ref_req == 1'b0, "R1", int'(ref_req), 0);
    check(ref_addr == '0, "R1", int'(ref_addr), 0);

    // R2 address load and unused select
    cfg_write(2'd1, 12'hABC);
    check(ref_addr == 12'hABC, "R2", int'(ref_addr), 'hABC);
    cfg_write(2'd3, 12'h123);
    check(ref_addr == 12'hABC, "R2", int'(ref_addr), 'hABC);

    // R4 interval nonzero but disabled, then enabled with interval 0
    cfg_write(2'd0, 2);
    quiet(300, seen);
    check(!seen, "R4", int'(seen), 0);
    cfg_write(2'd0, 0);
    cfg_write(2'd2, 1);
    quiet(300, seen);
    check(!seen, "R4", int'(seen), 0);

    // R3 / R5 / R6 / R11 table walk
    for (int i = 0; i < NVEC; i++) begin
      cfg_write(2'd0, TBL[i][0]);
      wait_req(k);
      check(k == TBL[i][1], (TBL[i][0] == 8) ? "R11" : "R3", k, TBL[i][1]);
      ref_grant = 1'b1;
      tick();
      ref_grant = 1'b0;
      check(!ref_req, "R5", int'(ref_req), 0);
      quiet(TBL[i][1] + 3, seen);
      check(!seen, "R6", int'(seen), 0);
      seq_done = 1'b1;
      tick();
      seq_done = 1'b0;
      wait_req(k);
      check(k == TBL[i][1], "R6", k, TBL[i][1]);
      serve();
    end

    // R7 two missed intervals replayed
    cfg_write(2'd0, 1);
    wait_req(k);
    check(k == 32, "R3", k, 32);
    repeat (70) tick();
    check(ref_req, "R5", int'(ref_req), 1);
    serve();
    check(ref_req, "R7", int'(ref_req), 1);
    serve();
    check(ref_req, "R7", int'(ref_req), 1);
    serve();
    check(!ref_req, "R7", int'(ref_req), 0);
    wait_req(k);
    check(k == 32, "R6", k, 32);
    serve();

    // R8 debt saturation after ten missed intervals
    cfg_write(2'd0, 1);
    wait_req(k);
    repeat (330) tick();
    n = 0;
    for (int j = 0; j < 12; j++) begin
      serve();
      if (ref_req) n++;
      else break;
    end
    check(n == 7, "R8", n, 7);

    // R9 stray done while idle and while waiting
    cfg_write(2'd0, 1);
    repeat (10) tick();
    seq_done = 1'b1;
    tick();
    seq_done = 1'b0;
    wait_req(k);
    check(k + 11 == 32, "R9", k + 11, 32);
    seq_done = 1'b1;
    tick();
    seq_done = 1'b0;
    check(ref_req, "R9", int'(ref_req), 1);
    serve();
    check(!ref_req, "R9", int'(ref_req), 0);

    // R10 rewriting the same interval restarts the count
    cfg_write(2'd0, 4);
    repeat (50) tick();
    cfg_write(2'd0, 4);
    wait_req(k);
    check(k == 128, "R10", k, 128);
    serve();

    // R4 disabling withdraws a waiting request and drops debt
    cfg_write(2'd0, 1);
    wait_req(k);
    repeat (40) tick();
    cfg_write(2'd2, 0);
    tick();
    check(!ref_req, "R4", int'(ref_req), 0);
    quiet(100, seen);
    check(!seen, "R4", int'(seen), 0);
    cfg_write(2'd2, 1);
    wait_req(k);
    check(k == 32, "R4", k, 32);
    serve();
    check(!ref_req, "R4", int'(ref_req), 0);

    cfg_write(2'd2, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule